// File: doc/BRIEF.md
# Supply-Sequenced Instruction Gate for a Serial Flash Model

This block sits between the opcode decoder of a serial flash model and the rest of its command logic, and decides which instructions may act while the supply ramps up or collapses. Two digital inputs stand in for supply comparators. `vwi_ok` means the rail is above the write-inhibit level. `vop_ok` means it is above the minimum operating level. While `vwi_ok` is low, the block holds everything behind it in reset and answers nothing.

Two permissions are timed separately, each by its own cycle counter. The read permission opens `RD_DLY` cycles after both comparators are high. The write permission opens `WR_DLY` cycles after the inhibit comparator alone is high. Reads can therefore be served before write-class instructions are allowed. A permission only opens if chip select is idle (high) at the moment its delay completes. Otherwise it stays locked until the supply input that feeds it drops again.

Accepted opcodes are forwarded with a one-cycle strobe. A write-class opcode that is filtered out produces a one-cycle reject strobe instead. The block also keeps the write-enable latch, the standby/deep power-down mode, and a sticky warning that is raised when the supply collapses during a busy write.

Top module: `sfg_power_gate`

## Requirements
- R1: While `rst` is high or `vwi_ok` is low, `core_rst` is high, both permissions are low, and no opcode produces `op_accept` or `op_reject`.
- R2: Once `vwi_ok` and `vop_ok` are both high, the read delay completes after `RD_DLY` rising edges. If `cs_n` is high at the next edge, `rd_permit` goes high after that edge, which is `RD_DLY+1` edges after the inputs rose.
- R3: `wr_permit` opens `WR_DLY+1` edges after `vwi_ok` rises, under the same chip-select rule, whatever the state of `vop_ok`.
- R4: A non-write-class opcode presented with `rd_permit` high gives `op_accept` high and `op_fwd` equal to the opcode one cycle later, even while `wr_permit` is low.
- R5: The write-class opcodes are 0x06, 0x02, 0xD8, 0xC7 and 0x01. One of them presented while `wr_permit` is low gives a one-cycle `op_reject` in the next cycle, no `op_accept`, and leaves `wel` unchanged.
- R6: If `cs_n` is low on the edge that follows completion of a delay, that permission stays low until its comparator input deasserts and the delay runs again.
- R7: On leaving reset, `wel` is 0 and `deep_pd` is 0 (standby).
- R8: An accepted 0x06 sets `wel`, and an accepted 0x04 clears it. Both changes are visible after the accepting edge.
- R9: An accepted 0xB9 sets `deep_pd`. While `deep_pd` is high, only 0xAB is accepted, and it clears `deep_pd`. Any other opcode is not accepted, and a write-class opcode is reported through `op_reject`.
- R10: When `vwi_ok` falls, `core_rst` rises and both permissions drop in the same cycle, with no clock edge needed.
- R11: `corrupt_warn` is set when `vwi_ok` falls while `wr_busy` is high, and it survives the supply-driven reset. It clears on the edge after the write delay next completes. A fall with `wr_busy` low does not set it.
- R12: A fall of `vop_ok` alone drops `rd_permit` in the same cycle and restarts the read delay, while `wr_permit` is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high model reset |
| vwi_ok | input | 1 | Supply above write-inhibit level |
| vop_ok | input | 1 | Supply above minimum operating level |
| cs_n | input | 1 | Chip select, active low |
| op_valid | input | 1 | Decoded opcode strobe |
| op_code | input | 8 | Decoded opcode |
| wr_busy | input | 1 | A program/erase/status write cycle is in progress |
| core_rst | output | 1 | Internal reset for logic behind the gate |
| rd_permit | output | 1 | Read-class instructions allowed |
| wr_permit | output | 1 | Write-class instructions allowed |
| op_accept | output | 1 | One-cycle strobe: opcode passed the gate |
| op_reject | output | 1 | One-cycle strobe: write-class opcode filtered |
| op_fwd | output | 8 | Opcode that was last accepted |
| wel | output | 1 | Write-enable latch |
| deep_pd | output | 1 | Deep power-down mode active |
| corrupt_warn | output | 1 | Sticky: supply collapsed during a busy write |

## Verification
The assertions assume that `op_valid` is a single-cycle strobe sampled on the rising edge. They also assume the comparator inputs change only between edges, since they are treated as already synchronous, and that `rst` is high at time zero. The stimulus drives every input on the falling clock edge, starts from an asserted `rst`, and raises `op_valid` for exactly one cycle per opcode. Supply falls and rises are placed at known cycle counts, so that each delay window can be checked at the exact edge where a permission should change.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

    typedef enum logic [1:0] {
        GATE_WAIT = 2'd0,
        GATE_OPEN = 2'd1,
        GATE_LOCK = 2'd2
    } gate_st_t;

    typedef enum logic {
        PM_STANDBY = 1'b0,
        PM_DEEP    = 1'b1
    } pwr_mode_t;

    localparam int unsigned OPW = 8;

    localparam logic [OPW-1:0] OP_WEN    = 8'h06;
    localparam logic [OPW-1:0] OP_WDIS   = 8'h04;
    localparam logic [OPW-1:0] OP_PROG   = 8'h02;
    localparam logic [OPW-1:0] OP_SERASE = 8'hD8;
    localparam logic [OPW-1:0] OP_BERASE = 8'hC7;
    localparam logic [OPW-1:0] OP_WSTAT  = 8'h01;
    localparam logic [OPW-1:0] OP_DEEP   = 8'hB9;
    localparam logic [OPW-1:0] OP_WAKE   = 8'hAB;

    typedef struct packed {
        logic           acc;
        logic           rej;
        logic [OPW-1:0] op;
    } verdict_t;

    function automatic logic is_write_class(input logic [OPW-1:0] op);
        return (op == OP_WEN) || (op == OP_PROG) || (op == OP_SERASE) ||
               (op == OP_BERASE) || (op == OP_WSTAT);
    endfunction

endpackage

// File: rtl/sfg_delay_timer.sv
module sfg_delay_timer #(
    parameter int unsigned LIMIT = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic done
);
    localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Restart whenever the qualifying input drops; saturate at the limit.
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (cnt != TOP) begin
            cnt <= cnt + CW'(1);
        end
    end

    // Combinational on en so a supply drop withdraws completion at once.
    assign done = en && (cnt == TOP);

endmodule

// File: rtl/sfg_permit_fsm.sv
module sfg_permit_fsm
    import sfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic done,
    input  logic cs_n,
    output logic permit
);
    gate_st_t st;

    // First edge with the delay complete samples chip select once;
    // a busy select at that edge locks the permission until done falls.
    always_ff @(posedge clk) begin
        if (rst || !done) begin
            st <= GATE_WAIT;
        end else if (st == GATE_WAIT) begin
            st <= cs_n ? GATE_OPEN : GATE_LOCK;
        end
    end

    assign permit = done && (st == GATE_OPEN);

endmodule

// File: rtl/sfg_op_filter.sv
module sfg_op_filter
    import sfg_pkg::*;
(
    input  logic           clk,
    input  logic           core_rst,
    input  logic           op_valid,
    input  logic [OPW-1:0] op_code,
    input  logic           rd_permit,
    input  logic           wr_permit,
    output logic           op_accept,
    output logic           op_reject,
    output logic [OPW-1:0] op_fwd,
    output logic           wel,
    output logic           deep_pd
);
    pwr_mode_t mode;
    verdict_t  nxt;
    verdict_t  cur;
    logic      wclass;
    logic      mode_ok;
    logic      perm;

    always_comb begin
        wclass  = is_write_class(op_code);
        mode_ok = (mode == PM_STANDBY) || (op_code == OP_WAKE);
        perm    = wclass ? wr_permit : rd_permit;
        nxt.acc = op_valid && !core_rst && mode_ok && perm;
        nxt.rej = op_valid && !core_rst && wclass && !nxt.acc;
        nxt.op  = op_code;
    end

    always_ff @(posedge clk) begin
        if (core_rst) begin
            cur  <= '0;
            wel  <= 1'b0;
            mode <= PM_STANDBY;
        end else begin
            cur.acc <= nxt.acc;
            cur.rej <= nxt.rej;
            if (nxt.acc) begin
                cur.op <= nxt.op;
                unique case (op_code)
                    OP_WEN:  wel  <= 1'b1;
                    OP_WDIS: wel  <= 1'b0;
                    OP_DEEP: mode <= PM_DEEP;
                    OP_WAKE: mode <= PM_STANDBY;
                    default: ;
                endcase
            end
        end
    end

    assign op_accept = cur.acc;
    assign op_reject = cur.rej;
    assign op_fwd    = cur.op;
    assign deep_pd   = (mode == PM_DEEP);

endmodule

// File: rtl/sfg_power_gate.sv
module sfg_power_gate
    import sfg_pkg::*;
#(
    parameter int unsigned RD_DLY = 20,
    parameter int unsigned WR_DLY = 50
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           vwi_ok,
    input  logic           vop_ok,
    input  logic           cs_n,
    input  logic           op_valid,
    input  logic [OPW-1:0] op_code,
    input  logic           wr_busy,
    output logic           core_rst,
    output logic           rd_permit,
    output logic           wr_permit,
    output logic           op_accept,
    output logic           op_reject,
    output logic [OPW-1:0] op_fwd,
    output logic           wel,
    output logic           deep_pd,
    output logic           corrupt_warn
);
    localparam int unsigned NCH = 2;   // channel 0: read, channel 1: write

    logic [NCH-1:0] ch_en;
    logic [NCH-1:0] ch_done;
    logic [NCH-1:0] ch_perm;
    logic           vwi_q;

    assign core_rst = rst || !vwi_ok;
    assign ch_en[0] = vwi_ok && vop_ok;
    assign ch_en[1] = vwi_ok;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam int unsigned LIM = (g == 0) ? RD_DLY : WR_DLY;

        sfg_delay_timer #(.LIMIT(LIM)) u_tmr (
            .clk  (clk),
            .rst  (rst),
            .en   (ch_en[g]),
            .done (ch_done[g])
        );

        sfg_permit_fsm u_fsm (
            .clk    (clk),
            .rst    (rst),
            .done   (ch_done[g]),
            .cs_n   (cs_n),
            .permit (ch_perm[g])
        );
    end

    assign rd_permit = ch_perm[0];
    assign wr_permit = ch_perm[1];

    sfg_op_filter u_filt (
        .clk       (clk),
        .core_rst  (core_rst),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .rd_permit (rd_permit),
        .wr_permit (wr_permit),
        .op_accept (op_accept),
        .op_reject (op_reject),
        .op_fwd    (op_fwd),
        .wel       (wel),
        .deep_pd   (deep_pd)
    );

    // Sticky warning lives outside the supply reset: only rst clears it
    // outright, otherwise a completed write delay does.
    always_ff @(posedge clk) begin
        if (rst) begin
            vwi_q        <= 1'b0;
            corrupt_warn <= 1'b0;
        end else begin
            vwi_q <= vwi_ok;
            if (vwi_q && !vwi_ok && wr_busy) begin
                corrupt_warn <= 1'b1;
            end else if (ch_done[1]) begin
                corrupt_warn <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sfg_power_gate_chk.sv
module sfg_power_gate_chk
    import sfg_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           vwi_ok,
    input logic           vop_ok,
    input logic           cs_n,
    input logic           op_valid,
    input logic [OPW-1:0] op_code,
    input logic           wr_busy,
    input logic           core_rst,
    input logic           rd_permit,
    input logic           wr_permit,
    input logic           op_accept,
    input logic           op_reject,
    input logic           wel,
    input logic           deep_pd,
    input logic           corrupt_warn
);
    // R1
    reset_closes_chk: assert property (@(posedge clk)
        core_rst |-> (!rd_permit && !wr_permit));

    // R10
    supply_drop_chk: assert property (@(posedge clk)
        !vwi_ok |-> (core_rst && !rd_permit && !wr_permit));

    // R12
    op_level_drop_chk: assert property (@(posedge clk)
        !vop_ok |-> !rd_permit);

    // R5
    write_filtered_chk: assert property (@(posedge clk) disable iff (core_rst)
        (op_valid && is_write_class(op_code) && !wr_permit)
        |=> (!op_accept && $stable(wel)));

    // R6
    idle_select_chk: assert property (@(posedge clk) disable iff (core_rst)
        $rose(rd_permit) |-> $past(cs_n));

    // R9
    deep_only_wake_chk: assert property (@(posedge clk) disable iff (core_rst)
        (deep_pd && op_valid && (op_code != OP_WAKE)) |=> !op_accept);

    // R7
    leave_reset_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(core_rst) && !core_rst) |-> (!wel && !deep_pd));

    // R11
    warn_set_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(vwi_ok) && !vwi_ok && wr_busy) |=> corrupt_warn);

    // R5
    strobe_excl_chk: assert property (@(posedge clk)
        $onehot0({op_accept, op_reject}));

endmodule

bind sfg_power_gate sfg_power_gate_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .vwi_ok       (vwi_ok),
    .vop_ok       (vop_ok),
    .cs_n         (cs_n),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .wr_busy      (wr_busy),
    .core_rst     (core_rst),
    .rd_permit    (rd_permit),
    .wr_permit    (wr_permit),
    .op_accept    (op_accept),
    .op_reject    (op_reject),
    .wel          (wel),
    .deep_pd      (deep_pd),
    .corrupt_warn (corrupt_warn)
);

// File: tb/sim_sfg_power_gate.sv
`timescale 1ns/1ps
module sim_sfg_power_gate;
    localparam int unsigned RD = 20;
    localparam int unsigned WR = 50;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vwi_ok = 1'b0, vop_ok = 1'b0, cs_n = 1'b1;
    logic       op_valid = 1'b0, wr_busy = 1'b0;
    logic [7:0] op_code = 8'h00;
    logic       core_rst, rd_permit, wr_permit, op_accept, op_reject;
    logic       wel, deep_pd, corrupt_warn;
    logic [7:0] op_fwd;

    int unsigned cyc = 0;
    int          checks = 0;
    int          errors = 0;

    typedef struct {
        int unsigned cyc;
        logic        acc;
        logic        rej;
        logic [7:0]  op;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    sfg_power_gate #(.RD_DLY(RD), .WR_DLY(WR)) u0 (
        .clk(clk), .rst(rst), .vwi_ok(vwi_ok), .vop_ok(vop_ok), .cs_n(cs_n),
        .op_valid(op_valid), .op_code(op_code), .wr_busy(wr_busy),
        .core_rst(core_rst), .rd_permit(rd_permit), .wr_permit(wr_permit),
        .op_accept(op_accept), .op_reject(op_reject), .op_fwd(op_fwd),
        .wel(wel), .deep_pd(deep_pd), .corrupt_warn(corrupt_warn)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_to(input int unsigned c);
        while (cyc < c) @(negedge clk);
    endtask

    // Driver: present one opcode for one cycle, queue the expected verdict.
    task automatic issue(input logic [7:0] op, input logic acc, input logic rej, input string tag);
        exp_t e;
        e.cyc = cyc; e.acc = acc; e.rej = rej; e.op = op; e.tag = tag;
        q.push_back(e);
        op_code  = op;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // Monitor: compare strobes one edge after each queued opcode.
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].cyc < cyc) begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " strobes"}, {30'd0, op_accept, op_reject}, {30'd0, e.acc, e.rej});
            if (e.acc) chk({e.tag, " fwd"}, {24'd0, op_fwd}, {24'd0, e.op});
        end else if (op_accept || op_reject) begin
            chk("unexpected strobe", {30'd0, op_accept, op_reject}, 32'd0);
        end
    end

    always @(negedge clk) begin
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned t;
        step(3);
        // R1 R7: reset state
        chk("R1 core_rst", core_rst, 1);
        chk("R1 rd_permit", rd_permit, 0);
        chk("R1 wr_permit", wr_permit, 0);
        chk("R7 wel", wel, 0);
        chk("R7 deep_pd", deep_pd, 0);
        rst = 1'b0;
        step(1);
        issue(8'h03, 0, 0, "R1 low supply");

        // R2: read opens RD+1 edges after both comparators rise
        vwi_ok = 1'b1; vop_ok = 1'b1; t = cyc;
        wait_to(t + RD);
        chk("R2 before", rd_permit, 0);
        step(1);
        chk("R2 open", rd_permit, 1);
        chk("R2 wr still closed", wr_permit, 0);
        chk("R7 wel after reset", wel, 0);
        chk("R7 standby after reset", deep_pd, 0);

        // R4 R5: reads pass, write class filtered
        issue(8'h03, 1, 0, "R4 read early");
        issue(8'h06, 0, 1, "R5 wen");
        chk("R5 wel unchanged", wel, 0);
        issue(8'h02, 0, 1, "R5 prog");
        issue(8'hD8, 0, 1, "R5 sector");
        issue(8'hC7, 0, 1, "R5 bulk");
        issue(8'h01, 0, 1, "R5 status");
        chk("R5 wel still 0", wel, 0);

        // R3: write opens WR+1 edges after inhibit comparator rose
        wait_to(t + WR);
        chk("R3 before", wr_permit, 0);
        step(1);
        chk("R3 open", wr_permit, 1);

        // R8
        issue(8'h06, 1, 0, "R8 set");
        chk("R8 wel set", wel, 1);
        issue(8'h04, 1, 0, "R8 clear");
        chk("R8 wel clear", wel, 0);
        issue(8'h06, 1, 0, "R8 set again");
        chk("R8 wel set again", wel, 1);

        // R9
        issue(8'hB9, 1, 0, "R9 enter");
        chk("R9 deep", deep_pd, 1);
        issue(8'h03, 0, 0, "R9 read blocked");
        issue(8'h02, 0, 1, "R9 write blocked");
        issue(8'hAB, 1, 0, "R9 wake");
        chk("R9 standby", deep_pd, 0);

        // R12: operating comparator drops alone
        vop_ok = 1'b0;
        #1;
        chk("R12 rd drop", rd_permit, 0);
        chk("R12 wr kept", wr_permit, 1);
        issue(8'h03, 0, 0, "R12 read filtered");
        issue(8'h06, 1, 0, "R12 write still ok");

        // R6: chip select busy when the read delay completes
        step(2);
        cs_n = 1'b0; vop_ok = 1'b1; t = cyc;
        wait_to(t + RD + 1);
        cs_n = 1'b1;
        step(3);
        chk("R6 locked", rd_permit, 0);
        issue(8'h03, 0, 0, "R6 read locked");
        vop_ok = 1'b0;
        step(1);
        vop_ok = 1'b1; t = cyc;
        wait_to(t + RD + 1);
        chk("R6 reopened", rd_permit, 1);

        // R10 R11: supply collapse during a busy write
        wr_busy = 1'b1; vwi_ok = 1'b0;
        #1;
        chk("R10 core_rst", core_rst, 1);
        chk("R10 rd", rd_permit, 0);
        chk("R10 wr", wr_permit, 0);
        step(1);
        wr_busy = 1'b0;
        chk("R11 warn set", corrupt_warn, 1);
        chk("R1 wel cleared", wel, 0);
        issue(8'h03, 0, 0, "R1 no answer");
        step(3);
        chk("R11 warn sticky", corrupt_warn, 1);
        vwi_ok = 1'b1; t = cyc;
        wait_to(t + WR);
        chk("R11 warn before", corrupt_warn, 1);
        step(1);
        chk("R11 warn cleared", corrupt_warn, 0);

        // R11 no-busy fall; R3 write opens without the operating comparator
        vwi_ok = 1'b0; vop_ok = 1'b0;
        step(1);
        chk("R11 no busy", corrupt_warn, 0);
        vwi_ok = 1'b1; t = cyc;
        wait_to(t + WR + 1);
        chk("R3 wr without vop", wr_permit, 1);
        chk("R3 rd closed", rd_permit, 0);
        issue(8'h06, 1, 0, "R3 wen");
        chk("R8 wel", wel, 1);
        step(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule